// File: doc/BRIEF.md
# Multidrop Serial Address Filter

This block sits between a 9-bit asynchronous serial receiver and the software of a slave node on a shared multidrop line. For every deframed byte the receiver presents, it decides whether the byte is delivered. A delivered byte is loaded into the receive buffer and raises the receive-complete flag. A byte that is not delivered is dropped without trace.

The block holds three items of state that software sets up: a node address register, a mask register and a filter-enable bit. In the two 9-bit serial modes with the enable bit set, only address frames are considered. An address frame has its ninth bit at 1. Such a frame is delivered only when it fits one of two patterns:

- The unicast pattern: the node address, restricted to the bit positions where the mask is 1.
- The broadcast pattern: all ones, restricted to the positions where the address OR the mask is 1.

After a hit, software clears the enable bit so that the data frames that follow are delivered normally. In the 8-bit modes, or with the enable bit clear, every byte is delivered.

Top module: `uart_maddr_top`

## Requirements
- R1: After reset, the receive flag is 0, the buffer is 0x00, the enable bit is 0, and the address and mask registers are 0. With both registers at 0, any address frame satisfies the unicast pattern.
- R2: When serialMode is 0 or 1 (the 8-bit modes, serialMode[1] = 0), every byte on rxValid is delivered, whatever the enable bit and ninth bit are.
- R3: When serialMode is 2 or 3 and the enable bit is 0, every byte on rxValid is delivered.
- R4: When serialMode is 2 or 3 and the enable bit is 1, a byte whose ninth bit is 0 is dropped. Neither the buffer nor the flag changes.
- R5: In the filtered case, an address frame is delivered when (byte XOR address) AND mask equals 0.
- R6: In the filtered case, an address frame is delivered when byte AND q equals q, where q = address OR mask.
- R7: In the filtered case, an address frame that fits neither pattern is dropped.
- R8: The flag stays at 1 until it is cleared. A delivered byte that arrives while the flag is set overwrites the buffer and leaves the flag at 1.
- R9: A flagClr pulse clears the flag on the next edge. When a delivered byte arrives in the same cycle as flagClr, the flag ends up at 1.
- R10: A delivered byte shows on rxBuf, and rxFlag rises, one clock after the rxValid cycle.
- R11: A register or enable-bit write takes effect from the next cycle. A byte arriving in the same cycle as the write is judged against the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| serialMode | input | 2 | Serial mode; values 2 and 3 are the 9-bit modes |
| cfgData | input | 8 | Write data for the configuration strobes |
| addrWr | input | 1 | Load the node address register from cfgData |
| maskWr | input | 1 | Load the mask register from cfgData |
| enWr | input | 1 | Load the enable bit from cfgData[0] |
| rxValid | input | 1 | One-cycle strobe: a deframed byte is present |
| rxByte | input | 8 | Received byte |
| rxBit9 | input | 1 | Received ninth bit |
| flagClr | input | 1 | Clear the receive flag |
| rxFlag | output | 1 | Receive-complete flag |
| rxBuf | output | 8 | Receive buffer |
| filterEn | output | 1 | Current enable bit |

## Verification
The case that is hardest to reach from the ports is a byte that satisfies the broadcast pattern but not the unicast pattern. Setting this up needs an address and a mask that disagree on some qualified bit, the enable bit set, a 9-bit mode and the ninth bit at 1, all at once. The directed part of the bench programs a mask of 0xFA and an address of 0xF1. It then sends bytes that were chosen by hand to hit only the unicast pattern, only the broadcast pattern, or neither. A long random phase follows, drawing from a small pool of masks and addresses so that both kinds of hit keep recurring. A behavioural model is compared with the outputs on every clock.

// File: rtl/uart_maddr_pkg.sv
package uart_maddr_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic loadBuf;
    logic loadAddr;
    logic loadMask;
  } rxCtl_t;
endpackage

// File: rtl/uart_maddr_dp.sv
module uart_maddr_dp
  import uart_maddr_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  rxCtl_t       ctl,
  input  logic [W-1:0] cfgData,
  input  logic [W-1:0] rxByte,
  output logic         unicastHit,
  output logic         bcastHit,
  output logic [W-1:0] rxBuf
);
  logic [W-1:0] nodeAddr;
  logic [W-1:0] nodeMask;
  logic [W-1:0] bcastQual;
  logic [W-1:0] uniMiss;
  logic [W-1:0] bcMiss;

  assign bcastQual = nodeAddr | nodeMask;

  // Per-bit compare; a bit only counts where its qualifier is set.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign uniMiss[i] = nodeMask[i]  & (rxByte[i] ^ nodeAddr[i]);
    assign bcMiss[i]  = bcastQual[i] & ~rxByte[i];
  end

  assign unicastHit = ~|uniMiss;
  assign bcastHit   = ~|bcMiss;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nodeAddr <= '0;
      nodeMask <= '0;
      rxBuf    <= '0;
    end else begin
      if (ctl.loadAddr) nodeAddr <= cfgData;
      if (ctl.loadMask) nodeMask <= cfgData;
      if (ctl.loadBuf)  rxBuf    <= rxByte;
    end
  end
endmodule

// File: rtl/uart_maddr_ctl.sv
module uart_maddr_ctl
  import uart_maddr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] serialMode,
  input  logic       enWr,
  input  logic       enData,
  input  logic       addrWr,
  input  logic       maskWr,
  input  logic       rxValid,
  input  logic       rxBit9,
  input  logic       flagClr,
  input  logic       unicastHit,
  input  logic       bcastHit,
  output rxCtl_t     ctl,
  output logic       rxFlag,
  output logic       filterEn
);
  logic nineBitMode;
  logic filtering;
  logic accept;

  assign nineBitMode = serialMode[1];
  assign filtering   = nineBitMode & filterEn;
  assign accept      = rxValid & (~filtering | (rxBit9 & (unicastHit | bcastHit)));

  always_comb begin
    ctl          = '0;
    ctl.loadBuf  = accept;
    ctl.loadAddr = addrWr;
    ctl.loadMask = maskWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxFlag   <= 1'b0;
      filterEn <= 1'b0;
    end else begin
      if (enWr) filterEn <= enData;
      // A delivered byte wins over a simultaneous clear.
      if (accept)       rxFlag <= 1'b1;
      else if (flagClr) rxFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_maddr_top.sv
module uart_maddr_top
  import uart_maddr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        serialMode,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              addrWr,
  input  logic              maskWr,
  input  logic              enWr,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxBit9,
  input  logic              flagClr,
  output logic              rxFlag,
  output logic [DATA_W-1:0] rxBuf,
  output logic              filterEn
);
  rxCtl_t ctl;
  logic   unicastHit;
  logic   bcastHit;

  uart_maddr_ctl ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .serialMode (serialMode),
    .enWr       (enWr),
    .enData     (cfgData[0]),
    .addrWr     (addrWr),
    .maskWr     (maskWr),
    .rxValid    (rxValid),
    .rxBit9     (rxBit9),
    .flagClr    (flagClr),
    .unicastHit (unicastHit),
    .bcastHit   (bcastHit),
    .ctl        (ctl),
    .rxFlag     (rxFlag),
    .filterEn   (filterEn)
  );

  uart_maddr_dp #(.W(DATA_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cfgData    (cfgData),
    .rxByte     (rxByte),
    .unicastHit (unicastHit),
    .bcastHit   (bcastHit),
    .rxBuf      (rxBuf)
  );
endmodule

// File: rtl/uart_maddr_chk.sv
module uart_maddr_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] serialMode,
  input logic       rxValid,
  input logic [7:0] rxByte,
  input logic       rxBit9,
  input logic       flagClr,
  input logic       enWr,
  input logic       rxFlag,
  input logic [7:0] rxBuf,
  input logic       filterEn
);
  a_r2_eight_bit_delivers: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !serialMode[1] |=> rxFlag && rxBuf == $past(rxByte));

  a_r3_unfiltered_delivers: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && serialMode[1] && !filterEn |=> rxFlag && rxBuf == $past(rxByte));

  a_r4_data_frame_dropped: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && serialMode[1] && filterEn && !rxBit9 |=>
      rxBuf == $past(rxBuf) && rxFlag == ($past(rxFlag) && !$past(flagClr)));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    rxFlag && !flagClr |=> rxFlag);

  a_r9_clear_idle: assert property (@(posedge clk) disable iff (!rstN)
    flagClr && !rxValid |=> !rxFlag);

  a_r10_buf_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> $stable(rxBuf));

  a_r11_enable_hold: assert property (@(posedge clk) disable iff (!rstN)
    !enWr |=> $stable(filterEn));
endmodule

bind uart_maddr_top uart_maddr_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .serialMode (serialMode),
  .rxValid    (rxValid),
  .rxByte     (rxByte),
  .rxBit9     (rxBit9),
  .flagClr    (flagClr),
  .enWr       (enWr),
  .rxFlag     (rxFlag),
  .rxBuf      (rxBuf),
  .filterEn   (filterEn)
);

// File: tb/uart_maddr_top_tb_top.sv
module uart_maddr_top_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] serialMode;
  logic [7:0] cfgData;
  logic       addrWr, maskWr, enWr;
  logic       rxValid;
  logic [7:0] rxByte;
  logic       rxBit9;
  logic       flagClr;
  logic       rxFlag;
  logic [7:0] rxBuf;
  logic       filterEn;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit       mFlag, mEn;
  bit [7:0] mBuf, mAddr, mMask;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_maddr_top dut_i (
    .clk(clk), .rstN(rstN), .serialMode(serialMode), .cfgData(cfgData),
    .addrWr(addrWr), .maskWr(maskWr), .enWr(enWr), .rxValid(rxValid),
    .rxByte(rxByte), .rxBit9(rxBit9), .flagClr(flagClr),
    .rxFlag(rxFlag), .rxBuf(rxBuf), .filterEn(filterEn)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit fitsPattern(bit [7:0] b, bit [7:0] pat, bit [7:0] care);
    for (int i = 0; i < 8; i++)
      if (care[i] && (b[i] != pat[i])) return 1'b0;
    return 1'b1;
  endfunction

  task automatic idle();
    addrWr = 0; maskWr = 0; enWr = 0; rxValid = 0; flagClr = 0;
    rxBit9 = 0; rxByte = 8'h00; cfgData = 8'h00;
  endtask

  // Apply current inputs for one clock, update the model, compare at negedge.
  task automatic step(input string tag);
    bit acc;
    @(posedge clk);
    acc = 0;
    if (rxValid) begin
      if (!serialMode[1] || !mEn) acc = 1;
      else if (rxBit9 && (fitsPattern(rxByte, mAddr, mMask) ||
                          fitsPattern(rxByte, 8'hFF, mAddr | mMask))) acc = 1;
    end
    if (flagClr) mFlag = 0;
    if (acc) begin mFlag = 1; mBuf = rxByte; end
    if (addrWr) mAddr = cfgData;
    if (maskWr) mMask = cfgData;
    if (enWr)   mEn   = cfgData[0];
    @(negedge clk);
    chk(tag, "rxFlag",   int'(rxFlag),   int'(mFlag));
    chk(tag, "rxBuf",    int'(rxBuf),    int'(mBuf));
    chk(tag, "filterEn", int'(filterEn), int'(mEn));
    idle();
  endtask

  task automatic sendByte(input string tag, input bit [1:0] md, input bit [7:0] b, input bit b9);
    serialMode = md; rxValid = 1; rxByte = b; rxBit9 = b9;
    step(tag);
  endtask

  task automatic writeReg(input string tag, input int which, input bit [7:0] d);
    cfgData = d;
    if (which == 0) addrWr = 1;
    else if (which == 1) maskWr = 1;
    else enWr = 1;
    step(tag);
  endtask

  task automatic clearFlag(input string tag);
    flagClr = 1;
    step(tag);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    idle();
    serialMode = 2'd0;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    mFlag = 0; mEn = 0; mBuf = 0; mAddr = 0; mMask = 0;
    // R1: reset state
    chk("R1", "rxFlag",   int'(rxFlag),   0);
    chk("R1", "rxBuf",    int'(rxBuf),    0);
    chk("R1", "filterEn", int'(filterEn), 0);

    // R2: 8-bit modes deliver regardless of enable and ninth bit
    sendByte("R2", 2'd0, 8'h55, 1'b0);
    clearFlag("R9");
    writeReg("R11", 2, 8'h01);
    sendByte("R2", 2'd1, 8'h3C, 1'b0);
    clearFlag("R9");

    // R1: cleared registers, any address frame fits the unicast pattern
    sendByte("R1", 2'd2, 8'hA3, 1'b1);
    clearFlag("R9");

    writeReg("R11", 0, 8'hF1);
    writeReg("R11", 1, 8'hFA);
    // R4: data frame dropped while filtering
    sendByte("R4", 2'd3, 8'h12, 1'b0);
    // R5: unicast hit 0xF0
    sendByte("R5", 2'd3, 8'hF0, 1'b1);
    clearFlag("R9");
    // R7: 0xF2 fits neither pattern
    sendByte("R7", 2'd3, 8'hF2, 1'b1);
    // R6: 0xFB fits broadcast only
    sendByte("R6", 2'd2, 8'hFB, 1'b1);
    // R8: overwrite while flag set
    sendByte("R8", 2'd2, 8'hFF, 1'b1);
    // R3: enable cleared, data frames delivered
    writeReg("R11", 2, 8'h00);
    sendByte("R3", 2'd2, 8'h34, 1'b0);
    // R9: clear with simultaneous delivered byte keeps flag
    flagClr = 1;
    sendByte("R9", 2'd2, 8'h77, 1'b0);
    // R9: clear with dropped byte clears flag
    writeReg("R11", 2, 8'h01);
    flagClr = 1;
    sendByte("R9", 2'd3, 8'h99, 1'b0);
    // R11: address write in same cycle as byte uses old address
    addrWr = 1; cfgData = 8'h0F;
    sendByte("R11", 2'd3, 8'h0F, 1'b1);
    sendByte("R11", 2'd3, 8'h0F, 1'b1);
    // R4: dropped byte leaves flag set and buffer intact
    sendByte("R4", 2'd2, 8'h00, 1'b0);

    // R10: random phase, compared each clock
    for (int n = 0; n < 2000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      serialMode = 2'($urandom_range(0, 3));
      if (r == 0) begin
        cfgData = ($urandom_range(0, 1) != 0) ? 8'hFA : 8'($urandom);
        maskWr = 1;
      end else if (r == 1) begin
        cfgData = ($urandom_range(0, 1) != 0) ? 8'hF1 : 8'($urandom);
        addrWr = 1;
      end else if (r == 2) begin
        cfgData = 8'($urandom); enWr = 1;
      end
      flagClr = ($urandom_range(0, 5) == 0);
      rxValid = ($urandom_range(0, 2) != 0);
      rxBit9  = 1'($urandom);
      rxByte  = ($urandom_range(0, 1) != 0) ? (8'hF0 | 8'($urandom_range(0, 15))) : 8'($urandom);
      step("R10");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule